// File: doc/BRIEF.md
# Page Write Protection Unit

This block guards a physical memory of 2^20 words, split into 1024 pages of 1K words each. It keeps two protect bits per page. One applies to writes made by the CPU and the other to writes made by a DMA master. On every bus cycle it looks up the page under the current physical address. It raises a write-protect flag when the current master writes a page that is protected for that master.

Beside the write check, a programmable bound names the highest page that is implemented. Any access, read or write, to a page above that bound raises an illegal-address flag.

The decision is taken in the first clock of the bus strobe and then held while the strobe stays active. Each flag therefore lasts exactly as long as the strobe. A plain configuration port updates one table entry per clock, and a separate port loads the bound. Both are control inputs with no back-pressure: a write enable held high for one clock commits one update.

Top module: `wpu_top`

## Requirements
- R1: After reset every page is unprotected for both masters and the bound is 1023, so no access raises either flag.
- R2: The page index is address bits [19:10]; bits [9:0] (word offset) have no effect on either flag.
- R3: A CPU write (bus_dma=0, bus_write=1) raises wp_flag exactly when bit 0 of the page's entry is 1.
- R4: A DMA write (bus_dma=1, bus_write=1) raises wp_flag exactly when bit 1 of the page's entry is 1; bit 0 has no effect on DMA writes and bit 1 has none on CPU writes.
- R5: A read (bus_write=0) never raises wp_flag, whatever the entry holds.
- R6: ill_flag is raised for reads and writes whose page index is strictly greater than the bound; a page equal to the bound is legal.
- R7: The flags change one clock after the strobe is first sampled high. They stay set for exactly as many clocks as the strobe is high and are low one clock after the strobe is sampled low.
- R8: Address, direction and master are sampled only in the first strobe clock; changes to them while the strobe stays high have no effect on the flags.
- R9: The table accepts one entry per clock (tbl_prot bit 0 = CPU protect, bit 1 = DMA protect). A lookup in the same clock as a write to that page still sees the old entry.
- R10: A bound write (bnd_we) takes effect for accesses starting from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_strobe | input | 1 | Bus data strobe, high for the duration of an access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| bus_addr | input | 20 | Physical word address |
| tbl_we | input | 1 | Protect-table write enable |
| tbl_page | input | 10 | Page index to update |
| tbl_prot | input | 2 | New entry: bit 0 CPU protect, bit 1 DMA protect |
| bnd_we | input | 1 | Bound write enable |
| bnd_page | input | 10 | Highest implemented page |
| wp_flag | output | 1 | Write-protect error |
| ill_flag | output | 1 | Illegal (unimplemented) address error |

## Verification
A corrupted table cell or a wrong page slice shows up as a wrong wp_flag on the first write to the affected page by the affected master. That happens one clock into the strobe. The bench therefore loads a computed pattern into every page and writes each page as CPU and as DMA. A stale bound or an off-by-one compare shows as ill_flag on the pages at and just above the bound in the same sweep. A bad hold or sampling state shows as flags that do not track strobe length, or that follow address changes made inside a strobe.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int ADDR_W_DEF = 20;
  localparam int OFS_W_DEF  = 10;

  // bit 1: DMA protect, bit 0: CPU protect
  typedef struct packed {
    logic dma;
    logic cpu;
  } prot_t;

  typedef enum logic {
    MST_CPU = 1'b0,
    MST_DMA = 1'b1
  } master_e;
endpackage

// File: rtl/wpu_prot_table.sv
module wpu_prot_table
  import wpu_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] wr_page,
  input  prot_t             wr_val,
  input  logic [PAGE_W-1:0] rd_page,
  output prot_t             rd_val
);
  localparam int NPAGES = 1 << PAGE_W;

  prot_t cells [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_cell
    prot_t cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cell_q <= '0;
      else if (we && (wr_page == PAGE_W'(g)))
        cell_q <= wr_val;
    end
    assign cells[g] = cell_q;
  end

  assign rd_val = cells[rd_page];

  // R9: a written entry is visible on the following clock
  a_r9_entry_update: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(wr_page)] == $past(wr_val)));
endmodule

// File: rtl/wpu_bound_reg.sv
module wpu_bound_reg #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] bound_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      bound_q <= '1;
    else if (we)
      bound_q <= din;
  end

  // R10: bound load
  a_r10_bound_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bound_q == $past(din)));
endmodule

// File: rtl/wpu_cycle_eval.sv
module wpu_cycle_eval
  import wpu_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              is_write,
  input  master_e           master,
  input  logic [PAGE_W-1:0] page,
  input  prot_t             entry,
  input  logic [PAGE_W-1:0] bound,
  output logic              wp_flag,
  output logic              ill_flag
);
  logic in_cyc_q;
  logic wp_q, ill_q;
  logic wp_now, ill_now;

  always_comb begin
    wp_now  = is_write && ((master == MST_DMA) ? entry.dma : entry.cpu);
    ill_now = (page > bound);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cyc_q <= 1'b0;
      wp_q     <= 1'b0;
      ill_q    <= 1'b0;
    end else if (strobe && !in_cyc_q) begin
      in_cyc_q <= 1'b1;
      wp_q     <= wp_now;
      ill_q    <= ill_now;
    end else if (!strobe) begin
      in_cyc_q <= 1'b0;
      wp_q     <= 1'b0;
      ill_q    <= 1'b0;
    end
  end

  assign wp_flag  = wp_q;
  assign ill_flag = ill_q;

  // R5: reads never flag write protection
  a_r5_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !in_cyc_q && !is_write) |=> !wp_flag);
  // R7: flags clear once the strobe ends
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!wp_flag && !ill_flag));
  // R8: flags held within a strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && in_cyc_q) |=> ($stable(wp_flag) && $stable(ill_flag)));
  // R6: out-of-bound page flagged
  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !in_cyc_q && (page > bound)) |=> ill_flag);
endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int OFS_W  = OFS_W_DEF,
  localparam int PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_strobe,
  input  logic              bus_write,
  input  logic              bus_dma,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              tbl_we,
  input  logic [PAGE_W-1:0] tbl_page,
  input  logic [1:0]        tbl_prot,
  input  logic              bnd_we,
  input  logic [PAGE_W-1:0] bnd_page,
  output logic              wp_flag,
  output logic              ill_flag
);
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] bound;
  prot_t             entry;
  prot_t             new_entry;
  master_e           master;
  logic              unused_ofs;

  assign page       = bus_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^bus_addr[OFS_W-1:0];
  assign new_entry  = prot_t'(tbl_prot);
  assign master     = bus_dma ? MST_DMA : MST_CPU;

  wpu_prot_table #(.PAGE_W(PAGE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .wr_page (tbl_page),
    .wr_val  (new_entry),
    .rd_page (page),
    .rd_val  (entry)
  );

  wpu_bound_reg #(.PAGE_W(PAGE_W)) u_bound (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bnd_we),
    .din     (bnd_page),
    .bound_q (bound)
  );

  wpu_cycle_eval #(.PAGE_W(PAGE_W)) u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (bus_strobe),
    .is_write (bus_write),
    .master   (master),
    .page     (page),
    .entry    (entry),
    .bound    (bound),
    .wp_flag  (wp_flag),
    .ill_flag (ill_flag)
  );
endmodule

// File: tb/wpu_top_test.sv
module wpu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0, bus_write = 1'b0, bus_dma = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_page = '0;
  logic [1:0]  tbl_prot = '0;
  logic        bnd_we = 1'b0;
  logic [9:0]  bnd_page = '0;
  logic        wp_flag, ill_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wpu_top uut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_dma(bus_dma), .bus_addr(bus_addr), .tbl_we(tbl_we), .tbl_page(tbl_page),
    .tbl_prot(tbl_prot), .bnd_we(bnd_we), .bnd_page(bnd_page),
    .wp_flag(wp_flag), .ill_flag(ill_flag)
  );

  function automatic logic [1:0] pat(int p);
    pat = {p[2] ^ p[5], p[0] ^ p[7]};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; strobe held for 'width' clocks, inputs scrambled mid-strobe (R8)
  task automatic do_access(input logic [19:0] a, input logic w, input logic d,
                           input int width, input logic ewp, input logic eill,
                           input string tag);
    bus_addr = a; bus_write = w; bus_dma = d; bus_strobe = 1'b1;
    for (int k = 0; k < width; k++) begin
      @(negedge clk);
      check({tag, " wp (R7/R8)"}, wp_flag, ewp);
      check({tag, " ill (R7/R8)"}, ill_flag, eill);
      if (k == 0) begin
        bus_addr = ~a; bus_write = ~w; bus_dma = ~d;
      end
    end
    bus_strobe = 1'b0;
    @(negedge clk);
    check({tag, " R7 wp clear"}, wp_flag, 1'b0);
    check({tag, " R7 ill clear"}, ill_flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wp in reset", wp_flag, 1'b0);
    check("R1 ill in reset", ill_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: defaults
    do_access({10'd1023, 10'd5}, 1'b1, 1'b0, 1, 1'b0, 1'b0, "R1 cpu wr top");
    do_access({10'd1023, 10'd9}, 1'b1, 1'b1, 1, 1'b0, 1'b0, "R1 dma wr top");
    do_access({10'd0, 10'd0},    1'b1, 1'b0, 1, 1'b0, 1'b0, "R1 cpu wr zero");
    // R9: load every page, one per clock
    for (int p = 0; p < 1024; p++) begin
      tbl_we = 1'b1; tbl_page = 10'(p); tbl_prot = pat(p);
      @(negedge clk);
    end
    tbl_we = 1'b0;
    bnd_we = 1'b1; bnd_page = 10'd700;
    @(negedge clk);
    bnd_we = 1'b0;
    // Sweep: R2 (varied offsets), R3, R4, R5, R6
    for (int p = 0; p < 1024; p++) begin
      logic [1:0] e;
      logic [19:0] a;
      e = pat(p);
      a = {10'(p), 10'((p * 37 + 11) % 1024)};
      do_access(a, 1'b1, 1'b0, 1, e[0], p > 700, "R3 R2 cpu write");
      do_access(a, 1'b1, 1'b1, 1, e[1], p > 700, "R4 R2 dma write");
      do_access(a, 1'b0, (p % 2) == 1, 1, 1'b0, p > 700, "R5 R6 read");
    end
    // R6 boundary
    do_access({10'd700, 10'd1}, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6 at bound");
    do_access({10'd701, 10'd1}, 1'b0, 1'b0, 1, 1'b0, 1'b1, "R6 above bound");
    // R7: longer strobes; page 1 pattern = 2'b01
    do_access({10'd1, 10'd3}, 1'b1, 1'b0, 4, 1'b1, 1'b0, "R7 len4 cpu");
    do_access({10'd702, 10'd3}, 1'b0, 1'b0, 3, 1'b0, 1'b1, "R7 len3 ill");
    // R9: same-clock write sees old value (page 0 pattern = 00)
    tbl_we = 1'b1; tbl_page = 10'd0; tbl_prot = 2'b01;
    bus_addr = 20'd0; bus_write = 1'b1; bus_dma = 1'b0; bus_strobe = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
    check("R9 same-clock old entry", wp_flag, 1'b0);
    bus_strobe = 1'b0;
    @(negedge clk);
    do_access(20'd0, 1'b1, 1'b0, 1, 1'b1, 1'b0, "R9 new entry cpu");
    do_access(20'd0, 1'b1, 1'b1, 1, 1'b0, 1'b0, "R4 cpu bit ignored by dma");
    // R10: bound reload
    bnd_we = 1'b1; bnd_page = 10'd1023;
    @(negedge clk);
    bnd_we = 1'b0;
    do_access({10'd1023, 10'd0}, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R10 bound max");
    bnd_we = 1'b1; bnd_page = 10'd0;
    @(negedge clk);
    bnd_we = 1'b0;
    do_access({10'd0, 10'd7}, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R10 bound zero legal");
    do_access({10'd1, 10'd7}, 1'b0, 1'b1, 1, 1'b0, 1'b1, "R10 bound zero illegal");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule